// File: doc/BRIEF.md
# Key Combination Detector

This block watches five active-low key lines and runs four independent combination detectors against them. Each detector holds a main key set and a hold time counted in ticks of a slow timebase strobe. It can also hold an optional pre-condition key set with its own hold time. When the pre-condition set is non-empty, the detector arms only after that set has been held long enough. Once armed, the main set must be held for its own time. When it is, the detector fires once. The firing drives the actions that the detector's action mask enables.

The actions are merged across the four detectors:
- a sticky battery-disable level;
- a sticky per-detector interrupt status bit, cleared by writing 1, together with an aggregate interrupt line;
- an embedded-controller reset pulse whose width in ticks is programmable;
- a one-cycle reset request.

All configuration arrives as flat input vectors. Register decoding, input synchronisation and configuration locking happen outside the block.

Top module: `keycombo_detect`

## Requirements
- R1: A key is pressed when its input bit is 0. Key bit order is key0, key1, key2, power button, AC-present (bit 0 to 4). A detector fires once all keys of its non-zero main mask have stayed pressed for main-time ticks. It does not fire earlier.
- R2: Hold time advances only on cycles where `tick_i` is 1. With the strobe held low, no detector ever fires.
- R3: If a required key is released before the hold time completes, that detector's count returns to zero.
- R4: A detector whose main mask is zero never fires.
- R5: A detector fires only once per press. It fires again only after at least one of its main keys has been released and the set is pressed again.
- R6: If a detector's pre-condition mask is non-zero, its main set does not count until the pre-condition keys have been held for pre-time ticks. Releasing the pre-condition keys early cancels the arming. Once armed, the detector stays armed until it fires.
- R7: Action mask bits per detector: bit 0 battery disable, bit 1 interrupt, bit 2 embedded-controller reset, bit 3 reset request. Only enabled actions occur. Interrupt fires set that detector's status bit, and `irq_o` is the OR of the status bits.
- R8: Writing 1 to a bit of `irq_clear_i` clears that status bit. If a set happens in the same cycle, the set wins.
- R9: `bat_disable_o` stays at 1 once set, until reset.
- R10: An embedded-controller reset action drives `ec_reset_o` high for `ec_width_i` ticks. A width of 0 gives no pulse.
- R11: A reset-request action gives a one-cycle pulse on `reset_req_o`.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase strobe, one cycle per tick |
| keys_n_i | input | 5 | Active-low key lines |
| pre_mask_i | input | 20 | Pre-condition key masks, 5 bits per detector |
| pre_time_i | input | 128 | Pre-condition hold times, 32 bits per detector |
| main_mask_i | input | 20 | Main key masks, 5 bits per detector |
| main_time_i | input | 128 | Main hold times, 32 bits per detector |
| action_i | input | 16 | Action masks, 4 bits per detector |
| ec_width_i | input | 16 | Embedded-controller reset pulse width in ticks |
| irq_clear_i | input | 4 | Write-1-to-clear strobes for the status bits |
| bat_disable_o | output | 1 | Sticky battery-disable level |
| ec_reset_o | output | 1 | Embedded-controller reset pulse |
| reset_req_o | output | 1 | One-cycle reset request |
| irq_status_o | output | 4 | Sticky per-detector interrupt status |
| irq_o | output | 1 | OR of the status bits |

## Verification
A stuck or mis-cleared hold counter shows up at the ports as a status bit that rises a tick too early or too late, or never. A lost or stuck "already fired" flag shows up as a second firing during one long press, or as no firing after a release and re-press. Both appear within a few cycles of the expected firing point. A wrong arming flag appears as a main combination that fires without its pre-condition, or that never fires after it. A miscounted pulse counter changes the measured high time of `ec_reset_o` by whole ticks.

// File: rtl/kc_pkg.sv
package kc_pkg;
  localparam int ACT_W   = 4;
  localparam int ACT_BAT = 0;
  localparam int ACT_IRQ = 1;
  localparam int ACT_EC  = 2;
  localparam int ACT_RST = 3;
endpackage

// File: rtl/kc_stage.sv
module kc_stage #(
  parameter int NKEY   = 5,
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              enable_i,
  input  logic [NKEY-1:0]   pressed_i,
  input  logic [NKEY-1:0]   mask_i,
  input  logic [TIME_W-1:0] limit_i,
  output logic              hit_o
);
  logic              held;
  logic              done_q;
  logic [TIME_W-1:0] cnt_q;

  assign held = enable_i && (mask_i != '0) && ((pressed_i & mask_i) == mask_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      hit_o  <= 1'b0;
    end else begin
      hit_o <= 1'b0;
      if (!held) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (!done_q) begin
        if (cnt_q >= limit_i) begin
          hit_o  <= 1'b1;
          done_q <= 1'b1;
        end else if (tick_i) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/kc_detector.sv
module kc_detector #(
  parameter int NKEY   = 5,
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [NKEY-1:0]   pressed_i,
  input  logic [NKEY-1:0]   pre_mask_i,
  input  logic [TIME_W-1:0] pre_time_i,
  input  logic [NKEY-1:0]   main_mask_i,
  input  logic [TIME_W-1:0] main_time_i,
  output logic              fire_o
);
  logic pre_hit;
  logic armed_q;
  logic main_en;

  kc_stage #(.NKEY(NKEY), .TIME_W(TIME_W)) u_pre (
    .clk(clk), .rst(rst), .tick_i(tick_i), .enable_i(1'b1),
    .pressed_i(pressed_i), .mask_i(pre_mask_i), .limit_i(pre_time_i),
    .hit_o(pre_hit)
  );

  assign main_en = armed_q || (pre_mask_i == '0);

  kc_stage #(.NKEY(NKEY), .TIME_W(TIME_W)) u_main (
    .clk(clk), .rst(rst), .tick_i(tick_i), .enable_i(main_en),
    .pressed_i(pressed_i), .mask_i(main_mask_i), .limit_i(main_time_i),
    .hit_o(fire_o)
  );

  always_ff @(posedge clk) begin
    if (rst)          armed_q <= 1'b0;
    else if (fire_o)  armed_q <= 1'b0;
    else if (pre_hit) armed_q <= 1'b1;
  end
endmodule

// File: rtl/kc_actions.sv
module kc_actions
  import kc_pkg::*;
#(
  parameter int NCOMBO  = 4,
  parameter int PULSE_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick_i,
  input  logic [NCOMBO-1:0]       fire_i,
  input  logic [NCOMBO*ACT_W-1:0] action_i,
  input  logic [PULSE_W-1:0]      ec_width_i,
  input  logic [NCOMBO-1:0]       irq_clear_i,
  output logic                    bat_disable_o,
  output logic                    ec_reset_o,
  output logic                    reset_req_o,
  output logic [NCOMBO-1:0]       irq_status_o,
  output logic                    irq_o
);
  logic [NCOMBO-1:0]  bat_set, irq_set, ec_set, rst_set;
  logic [NCOMBO-1:0]  status_nxt;
  logic [PULSE_W-1:0] ec_cnt_q;

  for (genvar i = 0; i < NCOMBO; i++) begin : g_sel
    assign bat_set[i] = fire_i[i] & action_i[i*ACT_W + ACT_BAT];
    assign irq_set[i] = fire_i[i] & action_i[i*ACT_W + ACT_IRQ];
    assign ec_set[i]  = fire_i[i] & action_i[i*ACT_W + ACT_EC];
    assign rst_set[i] = fire_i[i] & action_i[i*ACT_W + ACT_RST];
  end

  assign status_nxt = (irq_status_o & ~irq_clear_i) | irq_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      bat_disable_o <= 1'b0;
      reset_req_o   <= 1'b0;
      irq_status_o  <= '0;
      irq_o         <= 1'b0;
      ec_cnt_q      <= '0;
      ec_reset_o    <= 1'b0;
    end else begin
      bat_disable_o <= bat_disable_o | (|bat_set);
      reset_req_o   <= |rst_set;
      irq_status_o  <= status_nxt;
      irq_o         <= |status_nxt;
      if (|ec_set) begin
        ec_cnt_q   <= ec_width_i;
        ec_reset_o <= (ec_width_i != '0);
      end else if (tick_i && (ec_cnt_q != '0)) begin
        ec_cnt_q   <= ec_cnt_q - 1'b1;
        ec_reset_o <= (ec_cnt_q != PULSE_W'(1));
      end
    end
  end
endmodule

// File: rtl/keycombo_detect.sv
module keycombo_detect
  import kc_pkg::*;
#(
  parameter int NCOMBO  = 4,
  parameter int NKEY    = 5,
  parameter int TIME_W  = 32,
  parameter int PULSE_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick_i,
  input  logic [NKEY-1:0]          keys_n_i,
  input  logic [NCOMBO*NKEY-1:0]   pre_mask_i,
  input  logic [NCOMBO*TIME_W-1:0] pre_time_i,
  input  logic [NCOMBO*NKEY-1:0]   main_mask_i,
  input  logic [NCOMBO*TIME_W-1:0] main_time_i,
  input  logic [NCOMBO*ACT_W-1:0]  action_i,
  input  logic [PULSE_W-1:0]       ec_width_i,
  input  logic [NCOMBO-1:0]        irq_clear_i,
  output logic                     bat_disable_o,
  output logic                     ec_reset_o,
  output logic                     reset_req_o,
  output logic [NCOMBO-1:0]        irq_status_o,
  output logic                     irq_o
);
  logic [NKEY-1:0]   pressed;
  logic [NCOMBO-1:0] fire_w;

  assign pressed = ~keys_n_i;

  for (genvar i = 0; i < NCOMBO; i++) begin : g_det
    kc_detector #(.NKEY(NKEY), .TIME_W(TIME_W)) u_det (
      .clk(clk), .rst(rst), .tick_i(tick_i), .pressed_i(pressed),
      .pre_mask_i(pre_mask_i[i*NKEY +: NKEY]),
      .pre_time_i(pre_time_i[i*TIME_W +: TIME_W]),
      .main_mask_i(main_mask_i[i*NKEY +: NKEY]),
      .main_time_i(main_time_i[i*TIME_W +: TIME_W]),
      .fire_o(fire_w[i])
    );
  end

  kc_actions #(.NCOMBO(NCOMBO), .PULSE_W(PULSE_W)) u_act (
    .clk(clk), .rst(rst), .tick_i(tick_i), .fire_i(fire_w),
    .action_i(action_i), .ec_width_i(ec_width_i), .irq_clear_i(irq_clear_i),
    .bat_disable_o(bat_disable_o), .ec_reset_o(ec_reset_o),
    .reset_req_o(reset_req_o), .irq_status_o(irq_status_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/kc_checker.sv
module kc_checker
  import kc_pkg::*;
#(
  parameter int NCOMBO  = 4,
  parameter int NKEY    = 5,
  parameter int PULSE_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NKEY-1:0]         keys_n_i,
  input logic [NCOMBO*NKEY-1:0]  main_mask_i,
  input logic [NCOMBO*ACT_W-1:0] action_i,
  input logic [PULSE_W-1:0]      ec_width_i,
  input logic [NCOMBO-1:0]       irq_clear_i,
  input logic [NCOMBO-1:0]       fire,
  input logic [NCOMBO-1:0]       irq_status_o,
  input logic                    irq_o,
  input logic                    bat_disable_o,
  input logic                    ec_reset_o
);
  logic ec_start;
  always_comb begin
    ec_start = 1'b0;
    for (int i = 0; i < NCOMBO; i++)
      ec_start = ec_start | (fire[i] & action_i[i*ACT_W + ACT_EC]);
  end

  for (genvar i = 0; i < NCOMBO; i++) begin : g_chk
    // R1 and R4: a firing needs every key of a non-zero main mask pressed
    p_fire_keys_held_r1: assert property (@(posedge clk) disable iff (rst)
      fire[i] |-> $past((main_mask_i[i*NKEY +: NKEY] != '0) &&
        ((~keys_n_i & main_mask_i[i*NKEY +: NKEY]) == main_mask_i[i*NKEY +: NKEY])));
    // R5: never two firings back to back from one detector
    p_fire_once_r5: assert property (@(posedge clk) disable iff (rst)
      fire[i] |=> !fire[i]);
    // R8: a clear with no competing set empties the bit
    p_irq_clear_r8: assert property (@(posedge clk) disable iff (rst)
      (irq_clear_i[i] && !(fire[i] && action_i[i*ACT_W + ACT_IRQ])) |=> !irq_status_o[i]);
  end

  // R7: aggregate line follows status bits
  p_irq_or_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|irq_status_o));
  // R9: battery disable is sticky
  p_bat_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    bat_disable_o |=> bat_disable_o);
  // R10: a started pulse with non-zero width drives the reset line
  p_ec_start_r10: assert property (@(posedge clk) disable iff (rst)
    (ec_start && (ec_width_i != '0)) |=> ec_reset_o);
endmodule

bind keycombo_detect kc_checker #(.NCOMBO(NCOMBO), .NKEY(NKEY), .PULSE_W(PULSE_W)) u_kc_checker (
  .clk(clk), .rst(rst), .keys_n_i(keys_n_i), .main_mask_i(main_mask_i),
  .action_i(action_i), .ec_width_i(ec_width_i), .irq_clear_i(irq_clear_i),
  .fire(fire_w), .irq_status_o(irq_status_o), .irq_o(irq_o),
  .bat_disable_o(bat_disable_o), .ec_reset_o(ec_reset_o)
);

// File: tb/keycombo_detect_bench.sv
module keycombo_detect_bench;
  localparam int NC = 4, NK = 5, TW = 32, PW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic [NK-1:0] pressed_b = '0;
  logic [NC*NK-1:0] pre_mask = '0, main_mask = '0;
  logic [NC*TW-1:0] pre_time = '0, main_time = '0;
  logic [NC*4-1:0] action = '0;
  logic [PW-1:0] ec_width = '0;
  logic [NC-1:0] irq_clear = '0;
  logic bat, ec, rreq, irq;
  logic [NC-1:0] status;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  keycombo_detect u_keycombo_detect (
    .clk(clk), .rst(rst), .tick_i(tick), .keys_n_i(~pressed_b),
    .pre_mask_i(pre_mask), .pre_time_i(pre_time),
    .main_mask_i(main_mask), .main_time_i(main_time),
    .action_i(action), .ec_width_i(ec_width), .irq_clear_i(irq_clear),
    .bat_disable_o(bat), .ec_reset_o(ec), .reset_req_o(rreq),
    .irq_status_o(status), .irq_o(irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; step(2); rst = 1'b0; step(1);
  endtask

  task automatic clear_all();
    pressed_b = '0; step(2);
    irq_clear = '1; step(1); irq_clear = '0; step(1);
  endtask

  task automatic set_combo(input int i, input logic [4:0] pm, input logic [31:0] pt,
                           input logic [4:0] mm, input logic [31:0] mt, input logic [3:0] a);
    pre_mask[i*NK +: NK]   = pm;
    pre_time[i*TW +: TW]   = pt;
    main_mask[i*NK +: NK]  = mm;
    main_time[i*TW +: TW]  = mt;
    action[i*4 +: 4]       = a;
  endtask

  task automatic count_highs(input int n, output int n_ec, output int n_rq);
    n_ec = 0; n_rq = 0;
    for (int k = 0; k < n; k++) begin
      step(1);
      if (ec) n_ec++;
      if (rreq) n_rq++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n_ec, n_rq;
    void'($urandom(32'd20240611));
    step(1);
    do_reset();
    // R12: reset state
    chk("R12 outputs", {28'd0, bat, ec, rreq, irq}, 32'd0);
    chk("R12 status", {28'd0, status}, 32'd0);

    // R1: key0+key1, 6 ticks, interrupt action
    set_combo(0, 5'b0, 0, 5'b00011, 6, 4'b0010);
    pressed_b = 5'b00011; step(6);
    chk("R1 not early", {31'd0, status[0]}, 32'd0);
    step(3);
    chk("R1 fired", {31'd0, status[0]}, 32'd1);
    chk("R7 irq_o", {31'd0, irq}, 32'd1);
    pressed_b = '0; step(1);
    irq_clear = 4'b0001; step(1); irq_clear = '0;
    chk("R8 cleared", {31'd0, status[0]}, 32'd0);

    // R5: once per press
    pressed_b = 5'b00011; step(10);
    chk("R5 first", {31'd0, status[0]}, 32'd1);
    irq_clear = 4'b0001; step(1); irq_clear = '0; step(20);
    chk("R5 no refire", {31'd0, status[0]}, 32'd0);
    pressed_b = '0; step(2); pressed_b = 5'b00011; step(10);
    chk("R5 rearm", {31'd0, status[0]}, 32'd1);
    clear_all();

    // R3: release resets count
    pressed_b = 5'b00011; step(4); pressed_b = 5'b00001; step(1);
    pressed_b = 5'b00011; step(4);
    chk("R3 restart", {31'd0, status[0]}, 32'd0);
    step(5);
    chk("R3 completes", {31'd0, status[0]}, 32'd1);
    clear_all();

    // R2: no tick, no time
    tick = 1'b0; pressed_b = 5'b00011; step(30);
    chk("R2 frozen", {31'd0, status[0]}, 32'd0);
    tick = 1'b1; step(9);
    chk("R2 resumes", {31'd0, status[0]}, 32'd1);
    clear_all();

    // R4: zero mask
    set_combo(0, 5'b0, 0, 5'b0, 0, 4'b0000);
    set_combo(1, 5'b0, 0, 5'b0, 0, 4'b1010);
    pressed_b = 5'b11111; step(10);
    chk("R4 no fire", {31'd0, status[1]}, 32'd0);
    chk("R4 no request", {31'd0, rreq}, 32'd0);
    clear_all();

    // R6: pre-condition power button (bit 3) 5 ticks, then key0 for 3 ticks
    set_combo(2, 5'b01000, 5, 5'b00001, 3, 4'b0010);
    pressed_b = 5'b00001; step(20);
    chk("R6 needs arming", {31'd0, status[2]}, 32'd0);
    pressed_b = 5'b01000; step(3); pressed_b = '0; step(1);
    pressed_b = 5'b00001; step(10);
    chk("R6 short pre", {31'd0, status[2]}, 32'd0);
    pressed_b = 5'b01000; step(8); pressed_b = '0; step(2);
    pressed_b = 5'b00001; step(6);
    chk("R6 armed fire", {31'd0, status[2]}, 32'd1);
    clear_all();
    set_combo(2, 5'b0, 0, 5'b0, 0, 4'b0000);

    // R10, R11: AC-present (bit 4), 2 ticks, ec+request, width 7
    do_reset();
    ec_width = 16'd7;
    set_combo(3, 5'b0, 0, 5'b10000, 2, 4'b1100);
    pressed_b = 5'b10000;
    count_highs(30, n_ec, n_rq);
    chk("R10 pulse width", n_ec, 32'd7);
    chk("R11 single pulse", n_rq, 32'd1);
    chk("R7 no bat", {31'd0, bat}, 32'd0);
    chk("R7 no irq", {28'd0, status}, 32'd0);
    pressed_b = '0; step(2);
    ec_width = 16'd0;
    pressed_b = 5'b10000;
    count_highs(20, n_ec, n_rq);
    chk("R10 zero width", n_ec, 32'd0);
    pressed_b = '0; step(2);
    set_combo(3, 5'b0, 0, 5'b10000, 2, 4'b0001);
    pressed_b = 5'b10000;
    count_highs(10, n_ec, n_rq);
    chk("R9 bat set", {31'd0, bat}, 32'd1);
    chk("R7 bat only", n_rq, 32'd0);
    pressed_b = '0; step(5);
    chk("R9 sticky", {31'd0, bat}, 32'd1);
    do_reset();
    chk("R9 reset clears", {31'd0, bat}, 32'd0);
    set_combo(3, 5'b0, 0, 5'b0, 0, 4'b0000);

    // R1/R3 random: full masks fire, one missing key never fires
    for (int it = 0; it < 20; it++) begin
      logic [4:0] m, extra, low;
      logic [31:0] t;
      m = 5'($urandom_range(1, 31));
      extra = 5'($urandom);
      t = $urandom_range(0, 15);
      set_combo(0, 5'b0, 0, m, t, 4'b0010);
      pressed_b = m | extra; step(int'(t) + 4);
      chk("R1 random fire", {31'd0, status[0]}, 32'd1);
      clear_all();
      low = m & (~m + 5'd1);
      pressed_b = (m | extra) & ~low; step(int'(t) + 6);
      chk("R3 random missing key", {31'd0, status[0]}, 32'd0);
      clear_all();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule